// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a byte-wide CPU bus and a parallel NOR flash array that runs in byte mode. Each CPU write is turned into a flash address and checked against the command protocol. A two-write unlock prefix is followed by a command byte. The commands are: enter identification mode, program one byte, erase the whole array, erase one block, and return to array reads. Program and erase requests go out on a simple array port. An external behavioural or physical array carries them out.

The CPU address is not passed straight to the flash. CPU line 12 drives flash line 0, and CPU lines 0..11 drive flash lines 1..12. The flash lines above those come from a bank value that an external mapper supplies. Because of this swap, the CPU's command locations 0x4555 and 0x5AAA land on the flash's byte-mode unlock locations 0xAAA and 0x555. Block erase resolves the selected address against an uneven block map:

- one 16 KB block at 0x00000,
- two 8 KB blocks at 0x04000 and 0x06000,
- one 32 KB block at 0x08000,
- 64 KB blocks from 0x10000 upward.

After every program or erase, a busy flag stays high for a fixed number of cycles. Writes are refused while it is high.

Top module: `nor_flash_cmd_seq`

## Requirements
- R1: The array address is {bankHi, busAddr[11:0], busAddr[12]}, so it always stays within 2^AW bytes.
- R2: After reset the block is in array-read mode. busy and idMode are 0, no strobe is active, and busRdata equals arrRdata.
- R3: Writing 0xAA at flash low lines 0xAAA, then 0x55 at 0x555, then 0xA0 at 0xAAA makes the next accepted write a program cycle. In that cycle arrWe is 1 for one cycle at the swizzled address, with arrWdata = arrRdata AND busWdata. Afterwards the block returns to array-read mode.
- R4: The unlock prefix followed by 0x90 at 0xAAA enters identification mode. In that mode idMode is 1, busRdata is 0x5B, and writes other than 0xF0 are ignored.
- R5: The sequence unlock, 0x80 at 0xAAA, unlock, 0x10 at 0xAAA raises eraseReq for one cycle with eraseBase 0 and eraseLast 2^AW-1. The unlock here is 0xAA at 0xAAA followed by 0x55 at 0x555.
- R6: The same six-write sequence ending in 0x30 (at any address) raises eraseReq for the block that contains the final write's address. The blocks are:
  - 0x00000..0x03FFF,
  - 0x04000..0x05FFF,
  - 0x06000..0x07FFF,
  - 0x08000..0x0FFFF,
  - for addresses of 0x10000 and above, the aligned 64 KB range.
- R7: A wrong byte or a wrong address at any point within a sequence returns the block to array-read mode without any strobe.
- R8: A write of 0xF0 returns the block to array-read mode from every state except the program data cycle. This includes identification mode and any partial sequence.
- R9: After a program or erase strobe, busy is 1 for exactly BUSY_CYC cycles. Writes during that time cause no strobe and do not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | CPU write cycle, one clock per byte |
| busAddr | input | 13 | CPU address lines 0..12 |
| bankHi | input | AW-13 | Upper flash lines from the bank mapper |
| busWdata | input | 8 | CPU write data |
| busRdata | output | 8 | CPU read data (array data or device ID) |
| arrAddr | output | AW | Swizzled array address |
| arrRdata | input | 8 | Array read data at arrAddr |
| arrWe | output | 1 | Program strobe |
| arrWdata | output | 8 | Data to store (old AND new) |
| eraseReq | output | 1 | Erase strobe |
| eraseBase | output | AW | First byte of the erase range |
| eraseLast | output | AW | Last byte of the erase range |
| busy | output | 1 | Program or erase in progress |
| idMode | output | 1 | Identification mode active |

## Verification
A sequencer stuck in the wrong state shows up at the ports on the very next accepted write. Either a strobe appears where none is due, or the expected strobe is missing. Identification mode can also be seen straight away on busRdata. A swizzle error changes arrAddr in the same cycle and also breaks unlock matching. A wrong block-map boundary shows up in eraseBase and eraseLast during the strobe cycle. A busy counter that is off by one shows up as a run of busy cycles that is one too long or one too short.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;
  typedef enum logic [2:0] {
    ST_READ, ST_U1, ST_U2, ST_PROG, ST_E1, ST_E2, ST_E3, ST_AUTO
  } seqState_t;

  typedef struct packed {
    logic prog;
    logic chipErase;
    logic blockErase;
  } seqStrobe_t;

  localparam logic [11:0] UNLOCK_HI = 12'hAAA;
  localparam logic [11:0] UNLOCK_LO = 12'h555;
  localparam logic [7:0]  KEY_A     = 8'hAA;
  localparam logic [7:0]  KEY_B     = 8'h55;
  localparam logic [7:0]  OP_ID     = 8'h90;
  localparam logic [7:0]  OP_PGM    = 8'hA0;
  localparam logic [7:0]  OP_ERS    = 8'h80;
  localparam logic [7:0]  OP_CHIP   = 8'h10;
  localparam logic [7:0]  OP_BLK    = 8'h30;
  localparam logic [7:0]  OP_RST    = 8'hF0;
  localparam logic [7:0]  DEV_ID    = 8'h5B;
endpackage

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int BUSY_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [7:0]  busWdata,
  input  logic [11:0] cmdAddr,
  output seqStrobe_t  strobe,
  output logic        busy,
  output logic        idMode
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  seqState_t st, nxt;
  logic [CW-1:0] busyCnt;
  logic atHi, atLo;

  assign atHi = (cmdAddr == UNLOCK_HI);
  assign atLo = (cmdAddr == UNLOCK_LO);
  assign busy = (busyCnt != '0);
  assign idMode = (st == ST_AUTO);

  always_comb begin
    nxt = st;
    strobe = '0;
    if (busWr && !busy) begin
      unique case (st)
        ST_READ: if (busWdata == KEY_A && atHi) nxt = ST_U1;
        ST_U1:   nxt = (busWdata == KEY_B && atLo) ? ST_U2 : ST_READ;
        ST_U2: begin
          nxt = ST_READ;
          if (atHi) begin
            if (busWdata == OP_ID)  nxt = ST_AUTO;
            if (busWdata == OP_PGM) nxt = ST_PROG;
            if (busWdata == OP_ERS) nxt = ST_E1;
          end
        end
        ST_PROG: begin
          strobe.prog = 1'b1;
          nxt = ST_READ;
        end
        ST_E1:   nxt = (busWdata == KEY_A && atHi) ? ST_E2 : ST_READ;
        ST_E2:   nxt = (busWdata == KEY_B && atLo) ? ST_E3 : ST_READ;
        ST_E3: begin
          nxt = ST_READ;
          if (busWdata == OP_CHIP && atHi) strobe.chipErase = 1'b1;
          else if (busWdata == OP_BLK)     strobe.blockErase = 1'b1;
        end
        ST_AUTO: if (busWdata == OP_RST) nxt = ST_READ;
        default: nxt = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= ST_READ;
      busyCnt <= '0;
    end else begin
      st <= nxt;
      if (|strobe) busyCnt <= CW'(BUSY_CYC);
      else if (busy) busyCnt <= busyCnt - 1'b1;
    end
  end
endmodule

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [12:0]    busAddr,
  input  logic [AW-14:0] bankHi,
  input  logic [7:0]     busWdata,
  input  logic [7:0]     arrRdata,
  input  seqStrobe_t     strobe,
  input  logic           idMode,
  output logic [AW-1:0]  arrAddr,
  output logic [11:0]    cmdAddr,
  output logic [7:0]     busRdata,
  output logic           arrWe,
  output logic [7:0]     arrWdata,
  output logic           eraseReq,
  output logic [AW-1:0]  eraseBase,
  output logic [AW-1:0]  eraseLast
);
  localparam int BIG_SH = 16;
  logic [AW-1:0] blkBase, blkLast;

  assign arrAddr  = {bankHi, busAddr[11:0], busAddr[12]};
  assign cmdAddr  = arrAddr[11:0];
  assign busRdata = idMode ? DEV_ID : arrRdata;
  assign arrWe    = strobe.prog;
  assign arrWdata = arrRdata & busWdata;
  assign eraseReq = strobe.chipErase | strobe.blockErase;

  always_comb begin
    if (|arrAddr[AW-1:BIG_SH]) begin
      blkBase = {arrAddr[AW-1:BIG_SH], {BIG_SH{1'b0}}};
      blkLast = {arrAddr[AW-1:BIG_SH], {BIG_SH{1'b1}}};
    end else begin
      casez (arrAddr[15:13])
        3'b00?:  begin blkBase = AW'(20'h00000); blkLast = AW'(20'h03FFF); end
        3'b010:  begin blkBase = AW'(20'h04000); blkLast = AW'(20'h05FFF); end
        3'b011:  begin blkBase = AW'(20'h06000); blkLast = AW'(20'h07FFF); end
        default: begin blkBase = AW'(20'h08000); blkLast = AW'(20'h0FFFF); end
      endcase
    end
  end

  assign eraseBase = strobe.chipErase ? '0 : blkBase;
  assign eraseLast = strobe.chipErase ? '1 : blkLast;
endmodule

// File: rtl/nor_flash_cmd_seq.sv
module nor_flash_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW       = 20,
  parameter int BUSY_CYC = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           busWr,
  input  logic [12:0]    busAddr,
  input  logic [AW-14:0] bankHi,
  input  logic [7:0]     busWdata,
  output logic [7:0]     busRdata,
  output logic [AW-1:0]  arrAddr,
  input  logic [7:0]     arrRdata,
  output logic           arrWe,
  output logic [7:0]     arrWdata,
  output logic           eraseReq,
  output logic [AW-1:0]  eraseBase,
  output logic [AW-1:0]  eraseLast,
  output logic           busy,
  output logic           idMode
);
  seqStrobe_t strobe;
  logic [11:0] cmdAddr;

  nor_seq_ctrl #(.BUSY_CYC(BUSY_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busWdata(busWdata),
    .cmdAddr(cmdAddr), .strobe(strobe), .busy(busy), .idMode(idMode)
  );

  nor_seq_dp #(.AW(AW)) u_dp (
    .busAddr(busAddr), .bankHi(bankHi), .busWdata(busWdata),
    .arrRdata(arrRdata), .strobe(strobe), .idMode(idMode),
    .arrAddr(arrAddr), .cmdAddr(cmdAddr), .busRdata(busRdata),
    .arrWe(arrWe), .arrWdata(arrWdata), .eraseReq(eraseReq),
    .eraseBase(eraseBase), .eraseLast(eraseLast)
  );
endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rstN,
  input logic          busWr,
  input logic [7:0]    busWdata,
  input logic [7:0]    busRdata,
  input logic [7:0]    arrRdata,
  input logic          arrWe,
  input logic [7:0]    arrWdata,
  input logic          eraseReq,
  input logic [AW-1:0] eraseBase,
  input logic [AW-1:0] eraseLast,
  input logic          busy,
  input logic          idMode
);
  AST_PGM_BUSY: assert property (@(posedge clk) disable iff (!rstN) arrWe |=> busy); // R9
  AST_ERS_BUSY: assert property (@(posedge clk) disable iff (!rstN) eraseReq |=> busy); // R9
  AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rstN) busy |-> !arrWe && !eraseReq); // R9
  AST_PGM_CLEARS: assert property (@(posedge clk) disable iff (!rstN) arrWe |-> (arrWdata & ~arrRdata) == 8'h00); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN) !(arrWe && eraseReq)); // R5
  AST_ID_DATA: assert property (@(posedge clk) disable iff (!rstN) idMode |-> busRdata == 8'h5B); // R4
  AST_RANGE_ORDER: assert property (@(posedge clk) disable iff (!rstN) eraseReq |-> eraseLast > eraseBase); // R6
  AST_ID_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    idMode && busWr && !busy && busWdata == 8'hF0 |=> !idMode); // R8
  AST_WE_NEEDS_WR: assert property (@(posedge clk) disable iff (!rstN) (arrWe || eraseReq) |-> busWr); // R3
endmodule

bind nor_flash_cmd_seq nor_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busWdata(busWdata),
  .busRdata(busRdata), .arrRdata(arrRdata), .arrWe(arrWe),
  .arrWdata(arrWdata), .eraseReq(eraseReq), .eraseBase(eraseBase),
  .eraseLast(eraseLast), .busy(busy), .idMode(idMode)
);

// File: tb/sim_nor_flash_cmd_seq.sv
`timescale 1ns/100ps
module sim_nor_flash_cmd_seq;
  localparam int AW = 20;
  localparam int BUSY_CYC = 8;
  localparam int NV = 16;

  logic clk = 1'b0, rstN = 1'b0, busWr = 1'b0;
  logic [12:0] busAddr = '0;
  logic [AW-14:0] bankHi = '0;
  logic [7:0] busWdata = '0, arrRdata = 8'h00;
  logic [7:0] busRdata, arrWdata;
  logic [AW-1:0] arrAddr, eraseBase, eraseLast;
  logic arrWe, eraseReq, busy, idMode;

  int errors = 0, total = 0;
  logic sWe, sEr;
  logic [7:0] sWdata;
  logic [AW-1:0] sAddr, sBase, sLast;

  always #2 clk = ~clk;

  nor_flash_cmd_seq #(.AW(AW), .BUSY_CYC(BUSY_CYC)) u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .bankHi(bankHi),
    .busWdata(busWdata), .busRdata(busRdata), .arrAddr(arrAddr),
    .arrRdata(arrRdata), .arrWe(arrWe), .arrWdata(arrWdata),
    .eraseReq(eraseReq), .eraseBase(eraseBase), .eraseLast(eraseLast),
    .busy(busy), .idMode(idMode)
  );

  // bank[77:71] addr[70:58] data[57:50] rd[49:42] we[41] er[40] base[39:20] last[19:0]
  localparam logic [77:0] VEC [NV] = '{
    {7'h00, 13'h0555, 8'hAA, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h1AAA, 8'h55, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h0555, 8'hA0, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h11, 13'h0123, 8'h3C, 8'hF5, 1'b1, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h0555, 8'hAA, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h1AAA, 8'h55, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h0555, 8'h80, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h0555, 8'hAA, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h1AAA, 8'h55, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h03, 13'h0000, 8'h30, 8'h00, 1'b0, 1'b1, 20'h06000, 20'h07FFF},
    {7'h00, 13'h0555, 8'hAA, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h1AAA, 8'h55, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h0555, 8'h80, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h0555, 8'hAA, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h00, 13'h1AAA, 8'h55, 8'h00, 1'b0, 1'b0, 20'h0, 20'h0},
    {7'h09, 13'h0777, 8'h30, 8'h00, 1'b0, 1'b1, 20'h10000, 20'h1FFFF}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] bk, input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; bankHi = bk; busAddr = a; busWdata = d;
    #1;
    sWe = arrWe; sEr = eraseReq; sWdata = arrWdata;
    sAddr = arrAddr; sBase = eraseBase; sLast = eraseLast;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic unlock();
    wr(7'h00, 13'h0555, 8'hAA);
    wr(7'h00, 13'h1AAA, 8'h55);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic blkErase(input logic [6:0] bk, input logic [12:0] a,
                          input logic [AW-1:0] eb, input logic [AW-1:0] el);
    unlock(); wr(7'h00, 13'h0555, 8'h80);
    unlock(); wr(bk, a, 8'h30);
    check(sEr == 1'b1, "R6 erase strobe", 32'(sEr), 1);
    check(sBase == eb, "R6 base", 32'(sBase), 32'(eb));
    check(sLast == el, "R6 last", 32'(sLast), 32'(el));
    waitIdle();
  endtask

  initial begin
    #400000;
    errors++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    logic [77:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    arrRdata = 8'hC7;
    #1;
    check(busy == 1'b0 && idMode == 1'b0, "R2 reset flags", {busy, idMode}, 0);
    check(busRdata == 8'hC7, "R2 read passthrough", busRdata, 8'hC7);
    check(arrWe == 1'b0 && eraseReq == 1'b0, "R2 no strobe", {arrWe, eraseReq}, 0);

    bankHi = 7'h45; busAddr = 13'h1234; #1;
    check(arrAddr == 20'h8A469, "R1 swizzle", arrAddr, 20'h8A469);
    bankHi = 7'h7F; busAddr = 13'h1FFF; #1;
    check(arrAddr == 20'hFFFFF, "R1 top of array", arrAddr, 20'hFFFFF);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      arrRdata = v[49:42];
      wr(v[77:71], v[70:58], v[57:50]);
      check(sWe == v[41], "R3 program strobe", 32'(sWe), 32'(v[41]));
      check(sEr == v[40], "R6 erase strobe", 32'(sEr), 32'(v[40]));
      if (v[41]) begin
        check(sWdata == (v[49:42] & v[57:50]), "R3 AND data", sWdata, v[49:42] & v[57:50]);
        check(sAddr == {v[77:71], v[69:58], v[70]}, "R3 program address", sAddr, {v[77:71], v[69:58], v[70]});
      end
      if (v[40]) begin
        check(sBase == v[39:20], "R6 base", sBase, v[39:20]);
        check(sLast == v[19:0], "R6 last", sLast, v[19:0]);
      end
      waitIdle();
    end

    blkErase(7'h00, 13'h1FFF, 20'h00000, 20'h03FFF);
    blkErase(7'h02, 13'h0000, 20'h04000, 20'h05FFF);
    blkErase(7'h05, 13'h0100, 20'h08000, 20'h0FFFF);
    blkErase(7'h7F, 13'h0000, 20'hF0000, 20'hFFFFF);

    unlock(); wr(7'h00, 13'h0555, 8'h80); unlock(); wr(7'h00, 13'h0555, 8'h10);
    check(sEr == 1'b1, "R5 chip strobe", 32'(sEr), 1);
    check(sBase == '0 && sLast == '1, "R5 chip range", sLast, 20'hFFFFF);
    waitIdle();

    arrRdata = 8'h12;
    unlock(); wr(7'h00, 13'h0555, 8'h90);
    #1;
    check(idMode == 1'b1 && busRdata == 8'h5B, "R4 device id", busRdata, 8'h5B);
    wr(7'h00, 13'h0555, 8'hA0); wr(7'h00, 13'h0100, 8'h00);
    check(sWe == 1'b0 && idMode == 1'b1, "R4 writes ignored", {sWe, idMode}, 1);
    wr(7'h00, 13'h0000, 8'hF0);
    #1;
    check(idMode == 1'b0 && busRdata == 8'h12, "R8 exit id mode", busRdata, 8'h12);

    wr(7'h00, 13'h0555, 8'hAA); wr(7'h00, 13'h1AAA, 8'h77);
    wr(7'h00, 13'h1AAA, 8'h55); wr(7'h00, 13'h0555, 8'hA0);
    wr(7'h00, 13'h0100, 8'h00);
    check(sWe == 1'b0, "R7 bad byte aborts", 32'(sWe), 0);
    unlock(); wr(7'h00, 13'h0556, 8'hA0); wr(7'h00, 13'h0100, 8'h00);
    check(sWe == 1'b0, "R7 bad address aborts", 32'(sWe), 0);

    unlock(); wr(7'h00, 13'h0555, 8'h80); wr(7'h00, 13'h0000, 8'hF0);
    unlock(); wr(7'h00, 13'h0555, 8'h30);
    check(sEr == 1'b0, "R8 reset mid erase", 32'(sEr), 0);

    arrRdata = 8'hFF;
    unlock(); wr(7'h00, 13'h0555, 8'hA0); wr(7'h00, 13'h0040, 8'h0F);
    check(sWe == 1'b1, "R3 program before busy", 32'(sWe), 1);
    n = 0;
    while (busy && n < 20) begin n++; @(posedge clk); #1; end
    check(n == BUSY_CYC, "R9 busy length", n, BUSY_CYC);

    wr(7'h00, 13'h0040, 8'h0F);
    check(sWe == 1'b0, "R3 back to read mode", 32'(sWe), 0);
    unlock(); wr(7'h00, 13'h0555, 8'hA0); wr(7'h00, 13'h0040, 8'h01);
    unlock(); wr(7'h00, 13'h0555, 8'hA0); wr(7'h00, 13'h0040, 8'h02);
    check(sWe == 1'b0, "R9 writes ignored while busy", 32'(sWe), 0);
    waitIdle();
    wr(7'h00, 13'h0040, 8'h02);
    check(sWe == 1'b0, "R9 sequence not advanced", 32'(sWe), 0);

    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule